// File: doc/BRIEF.md
# Pulse-Density Audio Sample DAC

This block turns a stream of 8-bit audio samples into a one-bit pulse-density signal for an audio pin. A serial byte receiver presents each sample on a data bus that is meaningful only during the single clock in which its valid strobe is high. The block captures the byte on that strobe and keeps it in a holding register. The samples arrive as offset binary, where 0x00 is the most negative level, 0x80 is silence and 0xFF is the most positive level. The block flips the top bit to get a two's-complement value.

The signed sample first passes through a hold stage. That stage keeps the value seen by the modulator constant for a full accumulator period, 2^(SMP_W+1) clocks, after every change. A sample that arrives inside that window waits and is applied when the window ends. A 3-bit volume code sets how far the sample is shifted right arithmetically. The scaled value is re-biased to unsigned and drives a first-order delta-sigma accumulator whose carry is the one-bit stream. A final flip-flop registers the stream before it leaves the block.

At 11025 samples per second and a 50 MHz clock, samples are about 4535 clocks apart. The hold window of 512 clocks is therefore never the limit in normal use.

Top module: `pdm_audio_dac`

## Requirements
- R1: A byte on `smp_data_i` is captured only in a cycle where `smp_vld_i` is 1. Changes on the data bus while the strobe is 0 have no effect on the output.
- R2: Conversion to signed form inverts bit 7 only, so input 0x80 is signed zero. At any volume it gives exactly 256 ones in any 512 consecutive output bits.
- R3: The signed sample s is shifted right arithmetically by (7 - volume code). Code 7 is full scale. With a steady input, any 512 consecutive output bits hold exactly 2*((s >>> (7-vol)) + 128) ones.
- R4: Input 0xFF at volume code 7 gives exactly 510 ones per 512 output bits.
- R5: The modulator's input value changes at most once per 512 clocks. A sample captured inside that window is applied when it ends, and a later capture in the window replaces an earlier pending one.
- R6: While reset (active low, asynchronous) is asserted, `aud_o` is 0. After release, with no sample received, the output runs at exactly half density (256 of 512).
- R7: `aud_o` equals the modulator's one-bit output delayed by one clock.
- R8: Input 0x00 at volume code 7 gives no ones at all. Whenever the re-biased modulator input is zero, the next modulator bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_vld_i | input | 1 | One-cycle strobe marking a valid sample byte |
| smp_data_i | input | 8 | Offset-binary sample byte, valid with the strobe |
| vol_i | input | 3 | Volume code, 7 is full scale |
| aud_o | output | 1 | Registered pulse-density audio bit |

## Verification
The bench sweeps all eight volume codes against sixteen sample values from 0x00 to 0xFF. For each pair it counts the ones in a 512-clock window and compares the count with the exact arithmetic figure. A sign error, a wrong shift direction or a logical instead of arithmetic shift would bend the counts for negative samples. A missing top-bit inversion would move silence to a full-scale count. The bench also sends three strobes a few clocks apart. The first sample must set the density for a whole window, and only the last must follow. A design without the hold stage would switch early, and one that kept the first pending byte would land on the wrong density. Bus changes without a strobe and the idle density after reset are also checked, which catches a capture that follows the bus or a reset value other than mid-scale.

// File: rtl/pdm_dac_pkg.sv
package pdm_dac_pkg;
  localparam int unsigned DEF_SMP_W = 8;
  localparam int unsigned DEF_VOL_W = 3;
endpackage

// File: rtl/pdm_rst_sync.sv
module pdm_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/pdm_sample_hold.sv
module pdm_sample_hold #(
  parameter int unsigned SMP_W = pdm_dac_pkg::DEF_SMP_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    vld_i,
  input  logic [SMP_W-1:0]        data_i,
  output logic signed [SMP_W-1:0] mod_o
);
  localparam int unsigned TMR_W = SMP_W + 1;
  localparam logic [TMR_W-1:0] TMR_MAX = '1;

  logic signed [SMP_W-1:0] hold_q, hold_d;
  logic signed [SMP_W-1:0] mod_q, mod_d;
  logic                    pend_q, pend_d;
  logic [TMR_W-1:0]        tmr_q, tmr_d;
  logic                    load;

  always_comb begin
    load   = pend_q && (tmr_q == '0);
    hold_d = hold_q;
    if (vld_i) hold_d = {~data_i[SMP_W-1], data_i[SMP_W-2:0]};
    pend_d = vld_i | (pend_q & ~load);
    mod_d  = load ? hold_q : mod_q;
    if (load)             tmr_d = TMR_MAX;
    else if (tmr_q != '0) tmr_d = tmr_q - TMR_W'(1);
    else                  tmr_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      mod_q  <= '0;
      pend_q <= 1'b0;
      tmr_q  <= '0;
    end else begin
      hold_q <= hold_d;
      mod_q  <= mod_d;
      pend_q <= pend_d;
      tmr_q  <= tmr_d;
    end
  end

  assign mod_o = mod_q;

  // R1
  capture_on_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |=> (hold_q == {~$past(data_i[SMP_W-1]), $past(data_i[SMP_W-2:0])}));

  // R5
  hold_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_q != '0) |=> $stable(mod_q));
endmodule

// File: rtl/pdm_vol_scale.sv
module pdm_vol_scale #(
  parameter int unsigned SMP_W = pdm_dac_pkg::DEF_SMP_W,
  parameter int unsigned VOL_W = pdm_dac_pkg::DEF_VOL_W
) (
  input  logic signed [SMP_W-1:0] smp_i,
  input  logic [VOL_W-1:0]        vol_i,
  output logic [SMP_W-1:0]        ubias_o
);
  localparam logic [VOL_W-1:0] VOL_MAX = '1;

  logic [VOL_W-1:0]        shamt;
  logic signed [SMP_W-1:0] scaled;

  always_comb begin
    shamt   = VOL_MAX - vol_i;
    scaled  = smp_i >>> shamt;
    ubias_o = {~scaled[SMP_W-1], scaled[SMP_W-2:0]};
  end
endmodule

// File: rtl/pdm_dsm.sv
module pdm_dsm #(
  parameter int unsigned SMP_W = pdm_dac_pkg::DEF_SMP_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SMP_W-1:0] ubias_i,
  output logic             pdm_o
);
  logic [SMP_W-1:0] acc_q, acc_d;
  logic             bit_q, bit_d;
  logic [SMP_W:0]   sum;

  always_comb begin
    sum   = {1'b0, acc_q} + {1'b0, ubias_i};
    acc_d = sum[SMP_W-1:0];
    bit_d = sum[SMP_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      bit_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      bit_q <= bit_d;
    end
  end

  assign pdm_o = bit_q;

  // R8
  zero_input_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ubias_i == '0) |=> !bit_q);
endmodule

// File: rtl/pdm_audio_dac.sv
module pdm_audio_dac #(
  parameter int unsigned SMP_W = pdm_dac_pkg::DEF_SMP_W,
  parameter int unsigned VOL_W = pdm_dac_pkg::DEF_VOL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_vld_i,
  input  logic [SMP_W-1:0] smp_data_i,
  input  logic [VOL_W-1:0] vol_i,
  output logic             aud_o
);
  logic                    rst_n;
  logic signed [SMP_W-1:0] mod_smp;
  logic [SMP_W-1:0]        ubias;
  logic                    pdm_bit;
  logic                    aud_q, aud_d;

  pdm_rst_sync u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  pdm_sample_hold #(.SMP_W(SMP_W)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .vld_i  (smp_vld_i),
    .data_i (smp_data_i),
    .mod_o  (mod_smp)
  );

  pdm_vol_scale #(.SMP_W(SMP_W), .VOL_W(VOL_W)) u_scale (
    .smp_i   (mod_smp),
    .vol_i   (vol_i),
    .ubias_o (ubias)
  );

  pdm_dsm #(.SMP_W(SMP_W)) u_dsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .ubias_i (ubias),
    .pdm_o   (pdm_bit)
  );

  always_comb aud_d = pdm_bit;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) aud_q <= 1'b0;
    else        aud_q <= aud_d;
  end

  assign aud_o = aud_q;

  // R7
  out_reg_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    1'b1 |=> (aud_o == $past(pdm_bit)));
endmodule

// File: tb/pdm_audio_dac_bench.sv
`timescale 1ns/1ps
module pdm_audio_dac_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vld = 1'b0;
  logic [7:0] data = 8'h00;
  logic [2:0] vol = 3'd7;
  logic       aud;
  int         n_chk = 0;
  int         n_fail = 0;

  always #2.5 clk = ~clk;

  pdm_audio_dac u_pdm_audio_dac (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .smp_vld_i  (vld),
    .smp_data_i (data),
    .vol_i      (vol),
    .aud_o      (aud)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic strobe(input logic [7:0] b);
    @(negedge clk);
    data = b;
    vld  = 1'b1;
    @(negedge clk);
    vld  = 1'b0;
  endtask

  task automatic count_ones(input int n, output int ones);
    ones = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (aud) ones++;
    end
  endtask

  function automatic int expect_cnt(input int b, input int v);
    int s;
    s = b - 128;
    s = s >>> (7 - v);
    return 2 * (s + 128);
  endfunction

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
    $finish;
  end

  initial begin
    int ones;
    idle(4);
    // R6: output low in reset
    check(aud == 1'b0, "R6 reset level", aud, 0);
    rst_n = 1'b1;
    idle(10);
    count_ones(512, ones);
    check(ones == 256, "R6 idle half density", ones, 256);

    // R2: silence at every volume
    for (int v = 0; v < 8; v++) begin
      vol = 3'(v);
      strobe(8'h80);
      idle(530);
      count_ones(512, ones);
      check(ones == 256, "R2 mid-scale", ones, 256);
    end

    // R4 and R8 extremes
    vol = 3'd7;
    strobe(8'hFF);
    idle(530);
    count_ones(512, ones);
    check(ones == 510, "R4 full scale", ones, 510);
    strobe(8'h00);
    idle(530);
    count_ones(512, ones);
    check(ones == 0, "R8 most negative", ones, 0);

    // R1: bus changes without a strobe are ignored
    strobe(8'h40);
    idle(530);
    @(negedge clk);
    data = 8'hFF;
    idle(600);
    count_ones(512, ones);
    check(ones == 128, "R1 no capture without strobe", ones, 128);

    // R5: three strobes inside one window, first holds, last wins
    idle(20);
    @(negedge clk); data = 8'h40; vld = 1'b1;
    @(negedge clk); vld = 1'b0;
    idle(2);
    @(negedge clk); data = 8'h00; vld = 1'b1;
    @(negedge clk); vld = 1'b0;
    idle(2);
    @(negedge clk); data = 8'hC0; vld = 1'b1;
    @(negedge clk); vld = 1'b0;
    idle(4);
    count_ones(256, ones);
    check(ones == 64, "R5 first sample held for window", ones, 64);
    idle(300);
    count_ones(512, ones);
    check(ones == 384, "R5 last pending sample applied", ones, 384);

    // R3: sweep volume codes and sample values
    for (int v = 0; v < 8; v++) begin
      for (int k = 0; k < 16; k++) begin
        int b;
        b = k * 17;
        vol = 3'(v);
        strobe(8'(b));
        idle(530);
        count_ones(512, ones);
        check(ones == expect_cnt(b, v), "R3 volume scaled density", ones, expect_cnt(b, v));
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule